// File: doc/BRIEF.md
# Weekday and day-count alarm unit

This block keeps time of day (second, minute, hour) and the day of the week, advancing once for every one-clock pulse on a 1 Hz tick input. It carries two alarm sources. The weekly alarm compares the freshly advanced time against a programmed hour, minute and second, and fires only if the current weekday is selected in a seven-bit weekday mask. The counter alarm holds a day/hour/minute/second span that counts down by one second per tick while it is switched on, and fires on the tick that brings the span to zero.

Software reaches the block through a simple register port: a write strobe with address and data, and a separate combinational read address and data. Each alarm owns one status bit and one interrupt enable bit. Status bits are cleared by writing 1, and the single interrupt line is high while any status bit is set together with its enable bit.

A small sequencer handles each tick. Its states are SEQ_IDLE (waiting for a tick), SEQ_UPDATE (time advances and the countdown steps) and SEQ_MATCH (both alarms are evaluated and status is set). Transitions: SEQ_IDLE to SEQ_UPDATE when the tick input is 1; SEQ_UPDATE to SEQ_MATCH unconditionally; SEQ_MATCH to SEQ_IDLE unconditionally. A tick that arrives outside SEQ_IDLE is not taken.

Top module: `wkday_alarm_unit`

## Requirements
- R1: After reset every register reads 0 (time 00:00:00 on Monday, alarm settings, masks, enables, status) and irq is 0.
- R2: Register map by word address: 0 current time, 1 weekly alarm, 2 counter span, 3 alarm enables, 4 IRQ enable, 5 IRQ status; other addresses read 0. Time and weekly alarm hold seconds in bits 5:0, minutes in 13:8, hours in 20:16; the time register also holds the weekday in bits 31:29; the weekly alarm reads 0 in bits 31:29.
- R3: Each accepted tick adds one second; seconds wrap from 59 to 0 and carry into minutes, minutes wrap from 59 to 0 and carry into hours, hours wrap from 23 to 0.
- R4: Weekday codes are 0 = Monday through 6 = Sunday; an hour wrap advances the weekday, and 6 wraps to 0.
- R5: The enable register bits 6:0 select Monday..Sunday; when a tick leaves the time equal to the weekly alarm's hour, minute and second and the new weekday's bit is 1, IRQ status bit 1 is set.
- R6: If the new weekday's mask bit is 0, a time match does not set status bit 1.
- R7: Enable register bit 8 turns the counter alarm on; while on, each tick subtracts one second from the span (days in bits 31:24, hours 20:16, minutes 13:8, seconds 5:0), borrowing 0 seconds to 59, 0 minutes to 59, 0 hours to 23 from the next field up; the span reads back at address 2.
- R8: IRQ status bit 0 is set on the tick that takes the span from non-zero to zero; a span already at zero stays zero and sets nothing.
- R9: With enable bit 8 at 0, ticks leave the span unchanged.
- R10: Writing the status register clears each bit written as 1 and leaves bits written as 0; a set in the same cycle as a clear wins.
- R11: irq is 1 exactly when (status bit 0 AND enable bit 0) OR (status bit 1 AND enable bit 1), with bit 0 the counter alarm and bit 1 the weekly alarm.
- R12: A tick seen in SEQ_IDLE moves time on at the second clock edge and sets status at the third; a register write to time or span in the cycle of an update takes priority over the update.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_1hz | input | 1 | One-cycle pulse per second |
| reg_wr | input | 1 | Register write strobe |
| reg_waddr | input | 3 | Write word address |
| reg_wdata | input | 32 | Write data |
| reg_raddr | input | 3 | Read word address |
| reg_rdata | output | 32 | Read data (combinational) |
| irq | output | 1 | Interrupt request |

## Verification
The range assertions take for granted that software only writes legal field values (seconds and minutes up to 59, hours up to 23, weekday up to 6), and the stimulus draws every random field from those ranges. The sequencing checks assume tick pulses are one cycle wide and at least three cycles apart, which the bench guarantees by idling several cycles after each pulse. Random time and alarm values are mixed with chosen wrap points (end of minute, hour, day and week) and small spans so that countdown zero hits happen often.

// File: rtl/wka_pkg.sv
package wka_pkg;

    localparam int SEC_W  = 6;
    localparam int MIN_W  = 6;
    localparam int HR_W   = 5;
    localparam int WD_W   = 3;
    localparam int DAY_W  = 8;
    localparam int NUM_WD = 7;
    localparam int REG_AW = 3;
    localparam int REG_DW = 32;
    localparam int NUM_IRQ = 2;

    localparam logic [SEC_W-1:0] SEC_LAST = SEC_W'(59);
    localparam logic [MIN_W-1:0] MIN_LAST = MIN_W'(59);
    localparam logic [HR_W-1:0]  HR_LAST  = HR_W'(23);
    localparam logic [WD_W-1:0]  WD_LAST  = WD_W'(NUM_WD - 1);

    // field positions inside register words
    localparam int F_SEC    = 0;
    localparam int F_MIN    = 8;
    localparam int F_HR     = 16;
    localparam int F_DAY    = 24;
    localparam int F_WD     = 29;
    localparam int F_MASK   = 0;
    localparam int F_CNT_ON = 8;

    // status / enable bit positions
    localparam int IRQ_CNT = 0;
    localparam int IRQ_WK  = 1;

    localparam logic [REG_AW-1:0] A_TIME    = REG_AW'(0);
    localparam logic [REG_AW-1:0] A_WEEKLY  = REG_AW'(1);
    localparam logic [REG_AW-1:0] A_SPAN    = REG_AW'(2);
    localparam logic [REG_AW-1:0] A_ENABLE  = REG_AW'(3);
    localparam logic [REG_AW-1:0] A_IRQ_EN  = REG_AW'(4);
    localparam logic [REG_AW-1:0] A_IRQ_STA = REG_AW'(5);

    typedef struct packed {
        logic [WD_W-1:0]  wd;
        logic [HR_W-1:0]  hr;
        logic [MIN_W-1:0] mn;
        logic [SEC_W-1:0] sc;
    } tod_t;

    typedef struct packed {
        logic [DAY_W-1:0] dy;
        logic [HR_W-1:0]  hr;
        logic [MIN_W-1:0] mn;
        logic [SEC_W-1:0] sc;
    } span_t;

    typedef enum logic [1:0] {
        SEQ_IDLE   = 2'd0,
        SEQ_UPDATE = 2'd1,
        SEQ_MATCH  = 2'd2
    } seq_e;

    function automatic logic [REG_DW-1:0] tod_to_word(input tod_t t);
        logic [REG_DW-1:0] w;
        w = '0;
        w[F_SEC +: SEC_W] = t.sc;
        w[F_MIN +: MIN_W] = t.mn;
        w[F_HR  +: HR_W]  = t.hr;
        w[F_WD  +: WD_W]  = t.wd;
        return w;
    endfunction

    function automatic tod_t word_to_tod(input logic [REG_DW-1:0] w);
        tod_t t;
        t.sc = w[F_SEC +: SEC_W];
        t.mn = w[F_MIN +: MIN_W];
        t.hr = w[F_HR  +: HR_W];
        t.wd = w[F_WD  +: WD_W];
        return t;
    endfunction

    function automatic logic [REG_DW-1:0] span_to_word(input span_t s);
        logic [REG_DW-1:0] w;
        w = '0;
        w[F_SEC +: SEC_W] = s.sc;
        w[F_MIN +: MIN_W] = s.mn;
        w[F_HR  +: HR_W]  = s.hr;
        w[F_DAY +: DAY_W] = s.dy;
        return w;
    endfunction

    function automatic span_t word_to_span(input logic [REG_DW-1:0] w);
        span_t s;
        s.sc = w[F_SEC +: SEC_W];
        s.mn = w[F_MIN +: MIN_W];
        s.hr = w[F_HR  +: HR_W];
        s.dy = w[F_DAY +: DAY_W];
        return s;
    endfunction

endpackage

// File: rtl/wka_tod_core.sv
module wka_tod_core
    import wka_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  tod_t load_val,
    input  logic advance,
    output tod_t tod
);

    tod_t tod_q;
    tod_t tod_next;

    // one-second step with cascaded carries
    always_comb begin
        tod_next = tod_q;
        if (tod_q.sc >= SEC_LAST) begin
            tod_next.sc = '0;
            if (tod_q.mn >= MIN_LAST) begin
                tod_next.mn = '0;
                if (tod_q.hr >= HR_LAST) begin
                    tod_next.hr = '0;
                    if (tod_q.wd >= WD_LAST) begin
                        tod_next.wd = '0;
                    end else begin
                        tod_next.wd = tod_q.wd + 1'b1;
                    end
                end else begin
                    tod_next.hr = tod_q.hr + 1'b1;
                end
            end else begin
                tod_next.mn = tod_q.mn + 1'b1;
            end
        end else begin
            tod_next.sc = tod_q.sc + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tod_q <= '0;
        end else if (load) begin
            tod_q <= load_val;
        end else if (advance) begin
            tod_q <= tod_next;
        end
    end

    assign tod = tod_q;

endmodule

// File: rtl/wka_span_down.sv
module wka_span_down
    import wka_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  load,
    input  span_t load_val,
    input  logic  step,
    output span_t span,
    output logic  hit
);

    span_t span_q;
    span_t span_next;
    logic  hit_q;
    logic  is_zero;

    assign is_zero = (span_q == '0);

    // mixed-radix borrow chain: seconds, minutes, hours, days
    always_comb begin
        span_next = span_q;
        if (span_q.sc != '0) begin
            span_next.sc = span_q.sc - 1'b1;
        end else begin
            span_next.sc = SEC_LAST;
            if (span_q.mn != '0) begin
                span_next.mn = span_q.mn - 1'b1;
            end else begin
                span_next.mn = MIN_LAST;
                if (span_q.hr != '0) begin
                    span_next.hr = span_q.hr - 1'b1;
                end else begin
                    span_next.hr = HR_LAST;
                    span_next.dy = span_q.dy - 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            span_q <= '0;
            hit_q  <= 1'b0;
        end else if (load) begin
            span_q <= load_val;
            hit_q  <= 1'b0;
        end else if (step && !is_zero) begin
            span_q <= span_next;
            hit_q  <= (span_next == '0);
        end else begin
            hit_q  <= 1'b0;
        end
    end

    assign span = span_q;
    assign hit  = hit_q;

endmodule

// File: rtl/wka_irq_ctrl.sv
module wka_irq_ctrl #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_vec,
    input  logic         ien_wr,
    input  logic         sta_wr,
    input  logic [N-1:0] wdata,
    output logic [N-1:0] sta,
    output logic [N-1:0] ien,
    output logic         irq
);

    logic [N-1:0] sta_q;
    logic [N-1:0] ien_q;

    generate
        for (genvar i = 0; i < N; i++) begin : g_src
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    sta_q[i] <= 1'b0;
                    ien_q[i] <= 1'b0;
                end else begin
                    if (set_vec[i]) begin
                        sta_q[i] <= 1'b1;
                    end else if (sta_wr && wdata[i]) begin
                        sta_q[i] <= 1'b0;
                    end
                    if (ien_wr) begin
                        ien_q[i] <= wdata[i];
                    end
                end
            end
        end
    endgenerate

    assign sta = sta_q;
    assign ien = ien_q;
    assign irq = |(sta_q & ien_q);

endmodule

// File: rtl/wkday_alarm_unit.sv
module wkday_alarm_unit
    import wka_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_1hz,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_waddr,
    input  logic [REG_DW-1:0] reg_wdata,
    input  logic [REG_AW-1:0] reg_raddr,
    output logic [REG_DW-1:0] reg_rdata,
    output logic              irq
);

    seq_e state_q;
    seq_e state_d;

    logic do_advance;
    logic do_step;
    logic do_match;

    logic time_wr;
    logic span_wr;
    logic weekly_wr;
    logic enable_wr;
    logic ien_wr;
    logic sta_wr;

    tod_t  tod;
    span_t span;
    logic  span_hit;

    tod_t              wk_q;
    logic [NUM_WD-1:0] mask_q;
    logic              cnt_on_q;

    logic [NUM_IRQ-1:0] set_vec;
    logic [NUM_IRQ-1:0] sta;
    logic [NUM_IRQ-1:0] ien;
    logic               wk_hit;
    logic [NUM_WD:0]    mask_ext;

    // write decode
    assign time_wr   = reg_wr && (reg_waddr == A_TIME);
    assign weekly_wr = reg_wr && (reg_waddr == A_WEEKLY);
    assign span_wr   = reg_wr && (reg_waddr == A_SPAN);
    assign enable_wr = reg_wr && (reg_waddr == A_ENABLE);
    assign ien_wr    = reg_wr && (reg_waddr == A_IRQ_EN);
    assign sta_wr    = reg_wr && (reg_waddr == A_IRQ_STA);

    // sequencer: next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEQ_IDLE:   if (tick_1hz) state_d = SEQ_UPDATE;
            SEQ_UPDATE: state_d = SEQ_MATCH;
            SEQ_MATCH:  state_d = SEQ_IDLE;
            default:    state_d = SEQ_IDLE;
        endcase
    end

    // sequencer: state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // sequencer: outputs
    always_comb begin
        do_advance = 1'b0;
        do_step    = 1'b0;
        do_match   = 1'b0;
        unique case (state_q)
            SEQ_IDLE: ;
            SEQ_UPDATE: begin
                do_advance = 1'b1;
                do_step    = cnt_on_q;
            end
            SEQ_MATCH: do_match = 1'b1;
            default: ;
        endcase
    end

    // configuration registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wk_q     <= '0;
            mask_q   <= '0;
            cnt_on_q <= 1'b0;
        end else begin
            if (weekly_wr) begin
                wk_q    <= word_to_tod(reg_wdata);
                wk_q.wd <= '0;
            end
            if (enable_wr) begin
                mask_q   <= reg_wdata[F_MASK +: NUM_WD];
                cnt_on_q <= reg_wdata[F_CNT_ON];
            end
        end
    end

    wka_tod_core u_tod (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (time_wr),
        .load_val (word_to_tod(reg_wdata)),
        .advance  (do_advance),
        .tod      (tod)
    );

    wka_span_down u_span (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (span_wr),
        .load_val (word_to_span(reg_wdata)),
        .step     (do_step),
        .span     (span),
        .hit      (span_hit)
    );

    // weekly comparison on the freshly advanced time
    assign mask_ext = {1'b0, mask_q};
    assign wk_hit   = do_match
                   && (tod.hr == wk_q.hr)
                   && (tod.mn == wk_q.mn)
                   && (tod.sc == wk_q.sc)
                   && (tod.wd <= WD_LAST)
                   && mask_ext[tod.wd];

    always_comb begin
        set_vec          = '0;
        set_vec[IRQ_CNT] = do_match && span_hit;
        set_vec[IRQ_WK]  = wk_hit;
    end

    wka_irq_ctrl #(.N(NUM_IRQ)) u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_vec (set_vec),
        .ien_wr  (ien_wr),
        .sta_wr  (sta_wr),
        .wdata   (reg_wdata[NUM_IRQ-1:0]),
        .sta     (sta),
        .ien     (ien),
        .irq     (irq)
    );

    // read mux
    always_comb begin
        reg_rdata = '0;
        unique case (reg_raddr)
            A_TIME:    reg_rdata = tod_to_word(tod);
            A_WEEKLY:  reg_rdata = tod_to_word(wk_q);
            A_SPAN:    reg_rdata = span_to_word(span);
            A_ENABLE: begin
                reg_rdata[F_MASK +: NUM_WD] = mask_q;
                reg_rdata[F_CNT_ON]         = cnt_on_q;
            end
            A_IRQ_EN:  reg_rdata[NUM_IRQ-1:0] = ien;
            A_IRQ_STA: reg_rdata[NUM_IRQ-1:0] = sta;
            default:   reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/wka_checker.sv
module wka_checker
    import wka_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input seq_e               state,
    input tod_t               tod,
    input logic               time_wr,
    input logic [NUM_IRQ-1:0] sta,
    input logic [NUM_IRQ-1:0] ien,
    input logic               irq
);

    // R3
    sec_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tod.sc <= SEC_LAST) && (tod.mn <= MIN_LAST) && (tod.hr <= HR_LAST));

    // R4
    weekday_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tod.wd <= WD_LAST);

    // R3
    sec_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SEQ_UPDATE && !time_wr && tod.sc == SEC_LAST) |=> (tod.sc == '0));

    // R4
    week_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SEQ_UPDATE && !time_wr && tod.sc == SEC_LAST && tod.mn == MIN_LAST
         && tod.hr == HR_LAST && tod.wd == WD_LAST) |=> (tod.wd == '0));

    // R12
    tod_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != SEQ_UPDATE && !time_wr) |=> $stable(tod));

    // R12
    seq_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SEQ_UPDATE) |=> (state == SEQ_MATCH));

    // R12
    cnt_sta_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sta[IRQ_CNT]) |-> ($past(state) == SEQ_MATCH));

    // R12
    wk_sta_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sta[IRQ_WK]) |-> ($past(state) == SEQ_MATCH));

    // R11
    irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((sta == '0) || (ien == '0)) |-> !irq);

endmodule

bind wkday_alarm_unit wka_checker u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .state   (state_q),
    .tod     (tod),
    .time_wr (time_wr),
    .sta     (sta),
    .ien     (ien),
    .irq     (irq)
);

// File: tb/wkday_alarm_unit_tb.sv
module wkday_alarm_unit_tb;

    localparam logic [2:0] AD_TIME = 3'd0;
    localparam logic [2:0] AD_WK   = 3'd1;
    localparam logic [2:0] AD_SPAN = 3'd2;
    localparam logic [2:0] AD_EN   = 3'd3;
    localparam logic [2:0] AD_IEN  = 3'd4;
    localparam logic [2:0] AD_STA  = 3'd5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_1hz = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_waddr = '0;
    logic [31:0] reg_wdata = '0;
    logic [2:0]  reg_raddr = '0;
    logic [31:0] reg_rdata;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    wkday_alarm_unit u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_1hz  (tick_1hz),
        .reg_wr    (reg_wr),
        .reg_waddr (reg_waddr),
        .reg_wdata (reg_wdata),
        .reg_raddr (reg_raddr),
        .reg_rdata (reg_rdata),
        .irq       (irq)
    );

    function automatic logic [31:0] tw(int wd, int hr, int mn, int sc);
        return (32'(wd) << 29) | (32'(hr) << 16) | (32'(mn) << 8) | 32'(sc);
    endfunction

    function automatic logic [31:0] sw(int dy, int hr, int mn, int sc);
        return (32'(dy) << 24) | (32'(hr) << 16) | (32'(mn) << 8) | 32'(sc);
    endfunction

    function automatic logic [31:0] next_time(logic [31:0] w);
        int wd, secs;
        wd   = int'(w[31:29]);
        secs = int'(w[20:16]) * 3600 + int'(w[13:8]) * 60 + int'(w[5:0]) + 1;
        if (secs >= 86400) begin
            secs = 0;
            wd   = (wd + 1) % 7;
        end
        return tw(wd, secs / 3600, (secs / 60) % 60, secs % 60);
    endfunction

    function automatic logic [31:0] span_less_one(logic [31:0] w);
        int t;
        t = ((int'(w[31:24]) * 24 + int'(w[20:16])) * 60 + int'(w[13:8])) * 60 + int'(w[5:0]);
        if (t > 0) t = t - 1;
        return sw(t / 86400, (t / 3600) % 24, (t / 60) % 60, t % 60);
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [2:0] a, logic [31:0] d);
        @(negedge clk);
        reg_wr    = 1'b1;
        reg_waddr = a;
        reg_wdata = d;
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    task automatic rd(logic [2:0] a, output logic [31:0] d);
        reg_raddr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic tick1();
        @(negedge clk);
        tick_1hz = 1'b1;
        @(negedge clk);
        tick_1hz = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] d, t, nt, al, sp, ex;
        logic [6:0]  mask;
        bit          fired, exp_wk;
        void'($urandom(32'd20240611));

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        for (int a = 0; a < 6; a++) begin
            rd(3'(a), d);
            check("R1 reset reg", d, 32'h0);
        end
        check("R1 reset irq", 32'(irq), 32'h0);

        // R2 field layout and read back
        wr(AD_TIME, tw(6, 23, 59, 59));
        rd(AD_TIME, d);
        check("R2 time readback", d, tw(6, 23, 59, 59));
        wr(AD_WK, 32'hE013_2A05);
        rd(AD_WK, d);
        check("R2 weekly readback, weekday bits zero", d, 32'h0013_2A05);
        rd(3'd7, d);
        check("R2 unmapped reads 0", d, 32'h0);

        // R4 week wrap Sunday 23:59:59 -> Monday 00:00:00
        tick1();
        rd(AD_TIME, d);
        check("R4 week wrap", d, tw(0, 0, 0, 0));

        // R3 hour carry
        wr(AD_TIME, tw(1, 10, 59, 59));
        tick1();
        rd(AD_TIME, d);
        check("R3 hour carry", d, tw(1, 11, 0, 0));

        // R5 weekly alarm on an enabled weekday, R11 irq
        wr(AD_EN, 32'h0000_0004);
        wr(AD_WK, tw(0, 7, 30, 0));
        wr(AD_IEN, 32'h2);
        wr(AD_TIME, tw(2, 7, 29, 59));
        tick1();
        rd(AD_STA, d);
        check("R5 weekly status", d, 32'h2);
        check("R11 irq weekly", 32'(irq), 32'h1);

        // R10 write 0 keeps, write 1 clears
        wr(AD_STA, 32'h0);
        rd(AD_STA, d);
        check("R10 write zero keeps", d, 32'h2);
        wr(AD_STA, 32'h2);
        rd(AD_STA, d);
        check("R10 write one clears", d, 32'h0);
        check("R11 irq cleared", 32'(irq), 32'h0);

        // R6 weekday masked off
        wr(AD_EN, 32'h0000_007B);
        wr(AD_TIME, tw(2, 7, 29, 59));
        tick1();
        rd(AD_STA, d);
        check("R6 masked weekday", d, 32'h0);

        // R11 status set but enable off
        wr(AD_EN, 32'h0000_007F);
        wr(AD_IEN, 32'h1);
        wr(AD_TIME, tw(2, 7, 29, 59));
        tick1();
        rd(AD_STA, d);
        check("R5 weekly status again", d, 32'h2);
        check("R11 irq gated off", 32'(irq), 32'h0);
        wr(AD_STA, 32'h3);

        // R7 / R8 counter alarm to zero
        wr(AD_EN, 32'h0000_0100);
        wr(AD_SPAN, sw(0, 0, 0, 2));
        tick1();
        rd(AD_SPAN, d);
        check("R7 span step", d, sw(0, 0, 0, 1));
        rd(AD_STA, d);
        check("R8 not yet", d, 32'h0);
        tick1();
        rd(AD_SPAN, d);
        check("R8 span zero", d, 32'h0);
        rd(AD_STA, d);
        check("R8 counter status", d, 32'h1);
        check("R11 irq counter", 32'(irq), 32'h1);
        wr(AD_STA, 32'h1);
        tick1();
        rd(AD_STA, d);
        check("R8 zero span no refire", d, 32'h0);
        rd(AD_SPAN, d);
        check("R8 zero span stays", d, 32'h0);

        // R7 borrow across a day
        wr(AD_SPAN, sw(1, 0, 0, 0));
        tick1();
        rd(AD_SPAN, d);
        check("R7 day borrow", d, sw(0, 23, 59, 59));

        // R9 disabled counter holds
        wr(AD_EN, 32'h0);
        wr(AD_SPAN, sw(0, 0, 0, 5));
        tick1();
        rd(AD_SPAN, d);
        check("R9 span held", d, sw(0, 0, 0, 5));

        // R12 update priority: write in the update cycle wins
        wr(AD_TIME, tw(3, 5, 5, 5));
        @(negedge clk);
        tick_1hz = 1'b1;
        @(negedge clk);
        tick_1hz  = 1'b0;
        reg_wr    = 1'b1;
        reg_waddr = AD_TIME;
        reg_wdata = tw(4, 1, 2, 3);
        @(negedge clk);
        reg_wr = 1'b0;
        repeat (3) @(negedge clk);
        rd(AD_TIME, d);
        check("R12 write beats update", d, tw(4, 1, 2, 3));

        // random weekly alarm runs
        for (int i = 0; i < 40; i++) begin
            if ($urandom_range(3, 0) == 0)
                t = tw($urandom_range(6, 0), $urandom_range(23, 0), 59, 59);
            else
                t = tw($urandom_range(6, 0), $urandom_range(23, 0),
                       $urandom_range(59, 0), $urandom_range(59, 0));
            nt = next_time(t);
            if ($urandom_range(1, 0) == 1)
                al = nt & 32'h001F_3F3F;
            else
                al = tw(0, $urandom_range(23, 0), $urandom_range(59, 0), $urandom_range(59, 0));
            mask = 7'($urandom_range(127, 0));
            wr(AD_EN, {25'h0, mask});
            wr(AD_WK, al);
            wr(AD_TIME, t);
            wr(AD_STA, 32'h3);
            tick1();
            rd(AD_TIME, d);
            check("R3 random advance", d, nt);
            exp_wk = ((nt & 32'h001F_3F3F) == al) && mask[nt[31:29]];
            rd(AD_STA, d);
            check("R5 random weekly", d, exp_wk ? 32'h2 : 32'h0);
        end

        // random countdown runs
        for (int i = 0; i < 30; i++) begin
            if ($urandom_range(1, 0) == 1)
                sp = sw(0, 0, 0, $urandom_range(3, 0));
            else
                sp = sw($urandom_range(2, 0), $urandom_range(23, 0),
                        $urandom_range(59, 0), $urandom_range(59, 0));
            wr(AD_EN, 32'h0000_0100);
            wr(AD_SPAN, sp);
            wr(AD_STA, 32'h3);
            ex    = sp;
            fired = 1'b0;
            for (int n = $urandom_range(3, 1); n > 0; n--) begin
                if (ex != 0) begin
                    ex = span_less_one(ex);
                    if (ex == 0) fired = 1'b1;
                end
                tick1();
            end
            rd(AD_SPAN, d);
            check("R7 random countdown", d, ex);
            rd(AD_STA, d);
            check("R8 random zero hit", d, fired ? 32'h1 : 32'h0);
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule